// File: doc/BRIEF.md
# Supervision Watchdog with Saturating Fail Counter

This block supervises a host processor on behalf of a system controller. The host must pulse a service trigger regularly. In time-out mode a trigger is good at any point before the timer runs out. In window mode the period is split in two halves: a trigger in the early half counts as a failure, and a trigger in the late half counts as a good service. A period that ends with no trigger is also a failure.

On every failure the block pulls an active-low reset output low for a fixed number of cycles and, for one cycle, asks the surrounding power-mode logic to enter either restart mode or fail-safe mode. It keeps a two-bit count of failed services. This count stops rising at a ceiling that depends on the configuration code, and it drops to zero on a good service or whenever the watchdog is switched off.

The nominal period is `BASE_TICKS << per_sel_i`. The timer runs for 1.5 times that value, which places expiry inside the oscillator tolerance band of 1.2x to 1.8x. A trigger sent before 1.2x the nominal period is therefore always in time.

Top module: `wdog_supervisor`

## Requirements
- R1: In time-out mode (`win_mode_i`=0), a trigger at any timer count from 0 up to and including the last count L-1 is a good service. It restarts the period and does not pull reset low. Here L = P + P/2 and P = BASE_TICKS << per_sel_i.
- R2: When L cycles pass after a service point with no trigger, `wd_rst_n_o` is low in the cycle that follows the L-th clock edge. A service point is a good service, the end of a reset pulse, or the last cycle of block reset or of watchdog-off.
- R3: In window mode (`win_mode_i`=1), a trigger at count c < L/2 is a failure and a trigger at c >= L/2 is a good service.
- R4: Each failure raises `fail_cnt_o` by one. With `cfg_i`=2'b01 the count stops at 2'b01.
- R5: With `cfg_i` equal to 2'b00, 2'b10 or 2'b11 the count stops at 2'b10. It never reads 2'b11.
- R6: A good service clears `fail_cnt_o` to zero on the next edge.
- R7: The watchdog is off when `stop_wd_off_i` or `sleep_i` is high, or when `failsafe_i` is high and `failsafe_by_wd_i` is low. While it is off, the count is cleared, the timer is held at zero and triggers cause no failure.
- R8: When the fail-safe mode was caused by the watchdog (`failsafe_i`=1 and `failsafe_by_wd_i`=1), the watchdog stays on and the count is kept.
- R9: After a failure, `wd_rst_n_o` stays low for exactly RST_LEN cycles. Triggers during this pulse are ignored. The timer starts a new period when the pulse ends.
- R10: A failure raises exactly one of `req_restart_o` or `req_failsafe_o` for one cycle, aligned with the first low cycle of reset. Fail-safe is chosen when the count was already at its ceiling before that failure; otherwise restart is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| trig_i | input | 1 | Service trigger, one cycle per service |
| per_sel_i | input | 2 | Period select: P = BASE_TICKS << per_sel_i |
| win_mode_i | input | 1 | 0 = time-out mode, 1 = window mode |
| cfg_i | input | 2 | Configuration code; 2'b01 sets ceiling 1, the other codes set ceiling 2 |
| stop_wd_off_i | input | 1 | Stop mode with the watchdog disabled |
| sleep_i | input | 1 | Sleep mode |
| failsafe_i | input | 1 | Fail-safe mode |
| failsafe_by_wd_i | input | 1 | Fail-safe mode was entered through a watchdog failure |
| wd_rst_n_o | output | 1 | Active-low watchdog reset |
| fail_cnt_o | output | 2 | Saturating count of failed services |
| req_restart_o | output | 1 | One-cycle request to enter restart mode |
| req_failsafe_o | output | 1 | One-cycle request to enter fail-safe mode |

## Verification
The bench builds the block with BASE_TICKS=8 and RST_LEN=4. With these values a full time-out period is 12 cycles at select 0 and 24 cycles at select 1. This makes it cheap to test both sides of each boundary: the last count of a period, the exact middle of the window, and the last low cycle of the reset pulse. Short periods also let a few consecutive failures reach each saturation ceiling. Once a ceiling is reached, the bench can see the request switch from restart to fail-safe.

// File: rtl/wdog_pkg.sv
// Package: shared encodings and helpers for the supervision watchdog.
// Assumes the configuration code is two bits wide.
package wdog_pkg;

    // Configuration code that selects the low saturation ceiling.
    localparam logic [1:0] CFG_LOW_CEIL = 2'b01;

    typedef enum logic {
        WD_TIMEOUT = 1'b0,
        WD_WINDOW  = 1'b1
    } wd_mode_e;

    // Returns the fail-count ceiling for a configuration code.
    function automatic logic [1:0] fail_ceiling(input logic [1:0] cfg);
        return (cfg == CFG_LOW_CEIL) ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/wdog_period_timer.sv
// Period timer: counts cycles since the last service point and classifies
// triggers as good or failed services. Assumes BASE_TICKS >= 2 so that the
// closed half of the window is never empty.
module wdog_period_timer #(
    parameter int BASE_TICKS = 64,
    parameter int CNT_W      = $clog2(BASE_TICKS * 12 + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       trig,
    input  logic [1:0] per_sel,
    input  logic       win_mode,
    output logic       good_evt,
    output logic       bad_evt
);
    import wdog_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nominal;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] half;
    logic             in_closed;
    logic             expired;

    // Derive the nominal period, the stretched expiry length and the window split.
    always_comb begin
        nominal   = CNT_W'(BASE_TICKS) << per_sel;
        len       = nominal + (nominal >> 1);
        half      = len >> 1;
        in_closed = (wd_mode_e'(win_mode) == WD_WINDOW) && (cnt_q < half);
        expired   = (cnt_q >= len - CNT_W'(1));
    end

    // Classify this cycle's trigger, or the lack of one, as a service event.
    always_comb begin
        good_evt = !hold && trig && !in_closed;
        bad_evt  = !hold && ((trig && in_closed) || (!trig && expired));
    end

    // Advance the period counter; restart it on any event, on hold and on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || good_evt || bad_evt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdog_fail_counter.sv
// Fail counter: a two-bit saturating count of failed services, cleared by a
// good service or while the watchdog is off. Assumes good and bad events are
// never high together.
module wdog_fail_counter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       off,
    input  logic       good_evt,
    input  logic       bad_evt,
    input  logic [1:0] cfg,
    output logic [1:0] count,
    output logic       at_ceiling
);
    import wdog_pkg::*;

    logic [1:0] ceiling;

    // Look up the ceiling for the current configuration.
    always_comb begin
        ceiling    = fail_ceiling(cfg);
        at_ceiling = (count >= ceiling);
    end

    // Clear on good service or when off; otherwise count failures up to the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || off || good_evt) begin
            count <= 2'b00;
        end else if (bad_evt && !at_ceiling) begin
            count <= count + 2'b01;
        end
    end

endmodule

// File: rtl/wdog_reset_pulse.sv
// Reset pulse generator: holds an active-low reset for RST_LEN cycles after
// each fire pulse. Assumes RST_LEN >= 1 and that fire is not raised while
// the pulse is active.
module wdog_reset_pulse #(
    parameter int RST_LEN = 16,
    parameter int LEN_W   = $clog2(RST_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active,
    output logic rst_out_n
);
    logic [LEN_W-1:0] left_q;

    // Load the pulse length on fire and count it down to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            left_q <= '0;
        end else if (fire) begin
            active <= 1'b1;
            left_q <= LEN_W'(RST_LEN - 1);
        end else if (active) begin
            if (left_q == '0) begin
                active <= 1'b0;
            end else begin
                left_q <= left_q - LEN_W'(1);
            end
        end
    end

    // Drive the reset output low while the pulse is active.
    always_comb rst_out_n = !active;

endmodule

// File: rtl/wdog_supervisor.sv
// Top level: a supervision watchdog with time-out and window modes, a
// saturating fail counter, a reset pulse and one-cycle mode-change requests.
// Assumes the operating-mode inputs are already synchronous to clk.
module wdog_supervisor #(
    parameter int BASE_TICKS = 64,
    parameter int RST_LEN    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic [1:0] per_sel_i,
    input  logic       win_mode_i,
    input  logic [1:0] cfg_i,
    input  logic       stop_wd_off_i,
    input  logic       sleep_i,
    input  logic       failsafe_i,
    input  logic       failsafe_by_wd_i,
    output logic       wd_rst_n_o,
    output logic [1:0] fail_cnt_o,
    output logic       req_restart_o,
    output logic       req_failsafe_o
);
    logic wd_off;
    logic pulse_active;
    logic good_evt;
    logic bad_evt;
    logic at_ceiling;

    // The watchdog is off in stop-disabled, sleep, or a fail-safe not caused by it.
    always_comb wd_off = stop_wd_off_i || sleep_i || (failsafe_i && !failsafe_by_wd_i);

    wdog_period_timer #(
        .BASE_TICKS (BASE_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (wd_off || pulse_active),
        .trig     (trig_i),
        .per_sel  (per_sel_i),
        .win_mode (win_mode_i),
        .good_evt (good_evt),
        .bad_evt  (bad_evt)
    );

    wdog_fail_counter u_fail (
        .clk        (clk),
        .rst_n      (rst_n),
        .off        (wd_off),
        .good_evt   (good_evt),
        .bad_evt    (bad_evt),
        .cfg        (cfg_i),
        .count      (fail_cnt_o),
        .at_ceiling (at_ceiling)
    );

    wdog_reset_pulse #(
        .RST_LEN (RST_LEN)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (bad_evt),
        .active    (pulse_active),
        .rst_out_n (wd_rst_n_o)
    );

    // Register a one-cycle request, choosing fail-safe when already at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_restart_o  <= 1'b0;
            req_failsafe_o <= 1'b0;
        end else begin
            req_restart_o  <= bad_evt && !at_ceiling;
            req_failsafe_o <= bad_evt && at_ceiling;
        end
    end

endmodule

// File: rtl/wdog_supervisor_chk.sv
// Checker: temporal properties of the watchdog ports, attached by bind.
// Assumes the same port names as the top module.
module wdog_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_i,
    input logic [1:0] per_sel_i,
    input logic       win_mode_i,
    input logic [1:0] cfg_i,
    input logic       stop_wd_off_i,
    input logic       sleep_i,
    input logic       failsafe_i,
    input logic       failsafe_by_wd_i,
    input logic       wd_rst_n_o,
    input logic [1:0] fail_cnt_o,
    input logic       req_restart_o,
    input logic       req_failsafe_o
);
    // R10
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_restart_o && req_failsafe_o));

    // R10
    req_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_restart_o || req_failsafe_o) |-> !wd_rst_n_o);

    // R10
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_restart_o || req_failsafe_o) |=> !(req_restart_o || req_failsafe_o));

    // R5
    count_never_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_cnt_o != 2'b11);

    // R4
    low_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cfg_i) == 2'b01) && (fail_cnt_o != $past(fail_cnt_o))) |-> (fail_cnt_o <= 2'b01));

    // R7
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wd_off_i || sleep_i || (failsafe_i && !failsafe_by_wd_i)) |=> (fail_cnt_o == 2'b00));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt_o != $past(fail_cnt_o)) |-> ((fail_cnt_o == 2'b00) || (fail_cnt_o == $past(fail_cnt_o) + 2'b01)));

endmodule

bind wdog_supervisor wdog_supervisor_chk i_chk (.*);

// File: tb/test_wdog_supervisor.sv
// Scoreboard bench: the driver queues the expected requests, and a monitor
// pops and compares each one as the design raises it.
module test_wdog_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 8;
    localparam int RLEN       = 4;
    localparam int L0         = 12;
    localparam int L1         = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       win = 1'b0;
    logic [1:0] cfg = 2'b00;
    logic       stop_off = 1'b0;
    logic       sleep = 1'b0;
    logic       fsafe = 1'b0;
    logic       fsafe_wd = 1'b0;
    logic       wd_rst_n;
    logic [1:0] fail_cnt;
    logic       req_rs;
    logic       req_fs;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [2:0] exp_q[$];

    wdog_supervisor #(.BASE_TICKS(BASE), .RST_LEN(RLEN)) i_wdog_supervisor (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .per_sel_i(sel),
        .win_mode_i(win), .cfg_i(cfg), .stop_wd_off_i(stop_off),
        .sleep_i(sleep), .failsafe_i(fsafe), .failsafe_by_wd_i(fsafe_wd),
        .wd_rst_n_o(wd_rst_n), .fail_cnt_o(fail_cnt),
        .req_restart_o(req_rs), .req_failsafe_o(req_fs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        tick(1);
        trig = 1'b0;
    endtask

    // Expected request: {failsafe, count after the failure}
    task automatic expect_req(input logic fs, input logic [1:0] cnt);
        exp_q.push_back({fs, cnt});
    endtask

    // Monitor: compare each request raised by the design with the queue (R10)
    always @(negedge clk) begin
        if (rst_n && (req_rs || req_fs)) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10: actual unexpected request %0d expected none", {req_fs, req_rs});
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                check(req_fs == e[2] && req_rs == !e[2], "R10 request kind", int'(req_fs), int'(e[2]));
                check(fail_cnt == e[1:0], "R4/R5 count at request", int'(fail_cnt), int'(e[1:0]));
            end
        end
    end

    // Watchdog: end a hung run as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        check(wd_rst_n == 1'b1 && fail_cnt == 2'b00 && !req_rs && !req_fs, "R9 reset state", int'(fail_cnt), 0);

        // R1: time-out mode, triggers at count 10, count 0 and the last count 11
        tick(10); pulse_trig();
        check(wd_rst_n == 1'b1 && fail_cnt == 2'b00, "R1 trigger at count 10", int'(wd_rst_n), 1);
        pulse_trig();
        tick(L0 - 1); pulse_trig();
        check(wd_rst_n == 1'b1, "R1 trigger at last count", int'(wd_rst_n), 1);

        // R2: expiry at select 0, then R9 pulse length with a trigger ignored inside it
        tick(L0 - 1);
        check(wd_rst_n == 1'b1, "R2 high before expiry sel0", int'(wd_rst_n), 1);
        expect_req(1'b0, 2'b01);
        tick(1);
        check(wd_rst_n == 1'b0, "R2 low at expiry sel0", int'(wd_rst_n), 0);
        pulse_trig(); tick(RLEN - 2);
        check(wd_rst_n == 1'b0 && fail_cnt == 2'b01, "R9 still low, trigger ignored", int'(fail_cnt), 1);
        tick(1);
        check(wd_rst_n == 1'b1, "R9 release after RST_LEN", int'(wd_rst_n), 1);

        // R2: expiry at select 1 (L=24), count reaches ceiling 2
        sel = 2'b01;
        tick(L1 - 1);
        check(wd_rst_n == 1'b1, "R2 high before expiry sel1", int'(wd_rst_n), 1);
        expect_req(1'b0, 2'b10);
        tick(1);
        check(wd_rst_n == 1'b0, "R2 low at expiry sel1", int'(wd_rst_n), 0);
        tick(RLEN);
        check(fail_cnt == 2'b10, "R5 count at two", int'(fail_cnt), 2);

        // R3/R5/R10: window mode, closed trigger at count 2 with count at ceiling
        sel = 2'b00; win = 1'b1;
        tick(2); expect_req(1'b1, 2'b10); pulse_trig();
        check(wd_rst_n == 1'b0, "R3 closed trigger fails", int'(wd_rst_n), 0);
        check(fail_cnt == 2'b10, "R5 saturates at 2", int'(fail_cnt), 2);
        tick(RLEN);

        // R3/R6: open trigger at exactly L/2 is good and clears the count
        tick(L0 / 2); pulse_trig();
        check(wd_rst_n == 1'b1, "R3 open trigger at L/2", int'(wd_rst_n), 1);
        check(fail_cnt == 2'b00, "R6 good service clears", int'(fail_cnt), 0);

        // R3: last closed count L/2-1 fails
        tick(L0 / 2 - 1); expect_req(1'b0, 2'b01); pulse_trig();
        check(wd_rst_n == 1'b0, "R3 trigger at L/2-1 fails", int'(wd_rst_n), 0);
        tick(RLEN);

        // R4: configuration 01 saturates at 1 and requests fail-safe
        cfg = 2'b01;
        tick(1); expect_req(1'b1, 2'b01); pulse_trig();
        check(fail_cnt == 2'b01, "R4 saturates at 1", int'(fail_cnt), 1);
        tick(RLEN);

        // R7: sleep clears the count and holds the timer
        cfg = 2'b00; win = 1'b0;
        sleep = 1'b1; tick(1);
        check(fail_cnt == 2'b00, "R7 sleep clears count", int'(fail_cnt), 0);
        tick(29);
        check(wd_rst_n == 1'b1, "R7 timer held while off", int'(wd_rst_n), 1);
        sleep = 1'b0;
        tick(L0 - 1);
        check(wd_rst_n == 1'b1, "R7 fresh period after off", int'(wd_rst_n), 1);
        expect_req(1'b0, 2'b01);
        tick(1);
        check(wd_rst_n == 1'b0, "R7 expiry after off", int'(wd_rst_n), 0);
        tick(RLEN);

        // R8: fail-safe caused by the watchdog keeps the count
        fsafe = 1'b1; fsafe_wd = 1'b1; tick(3);
        check(fail_cnt == 2'b01, "R8 count kept in fail-safe by watchdog", int'(fail_cnt), 1);
        fsafe_wd = 1'b0; tick(1);
        check(fail_cnt == 2'b00, "R7 other fail-safe clears", int'(fail_cnt), 0);
        fsafe = 1'b0;

        // R7: stop with watchdog disabled clears the count
        win = 1'b1;
        tick(1); expect_req(1'b0, 2'b01); pulse_trig();
        tick(RLEN);
        stop_off = 1'b1; tick(1);
        check(fail_cnt == 2'b00, "R7 stop-disabled clears count", int'(fail_cnt), 0);
        stop_off = 1'b0;

        tick(5);
        check(exp_q.size() == 0, "R10 all expected requests seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule